// File: doc/BRIEF.md
# SMBus Register Slave with Alert Response

This block is the serial front end of a two-channel temperature monitor. It watches the two bus lines with the system clock, cleans them with a synchronizer and a short glitch filter, and finds start, repeated start and stop conditions. It receives and sends bytes MSB first in nine-clock frames and acknowledges through an open-drain enable on the data line. Behind it sits the monitor's register file, which it reaches through a plain strobe port: a one-cycle read strobe with the data returned in the same cycle, and a one-cycle write strobe with address and data.

A write transaction always begins by loading an address pointer. The pointer keeps its value between transactions, so a read that needs another register sets the pointer and then issues a repeated start. Several control registers have one address for reads and a different one for writes; the slave folds each write address onto the read address before it reaches the register file. Two identification addresses are answered inside the block.

The block also answers the alert response address while the monitor has an alert pending. It returns its own address and signals the alarm logic that the alert was serviced. A bus-timeout reset returns the slave to idle when a bus line is stuck low. Software turns it on through bit 7 of register 22h, which the slave copies as the write goes past.

Top module: `smb_reg_slave`

## Requirements
- R1: After a start, a byte of 98h (address 4Ch, write) or 99h (address 4Ch, read) gets an ACK in the ninth clock. Data bits are taken MSB first on rising SCL, and SDA is pulled low for the ACK clock only.
- R2: Any other address byte (except R8) gets no ACK. The slave then leaves SDA released and issues no strobe until the next start.
- R3: The first byte after a write address loads the pointer, and a repeated start followed by a read returns the pointed register. The pointer keeps its value across transactions, so a read with no pointer set returns the register last pointed to. A byte that follows the pointer without a repeated start is written to the pointed register.
- R4: Writes to 09h through 0Eh reach the register file at that address minus 06h (03h through 08h). Reads of 03h through 08h go to the register file unchanged.
- R5: 11h-14h, 19h and 20h-22h share one address for reads and writes. 0Fh is write-only. Reads of FEh return 61h and reads of FFh return 00h without a read strobe, and reads of the write-only addresses 09h-0Fh return 00h.
- R6: A pointer byte naming an unimplemented address gets a NACK. The pointer keeps its old value, and the rest of the transaction is ignored.
- R7: A data byte written to a read-only address (00h-08h, 10h, FEh, FFh) is acknowledged but produces no write strobe.
- R8: Byte 19h (alert response address 0Ch, read) is acknowledged only while alert_req is high. The slave then sends 99h, and alert_done pulses for one cycle when the master's acknowledge bit is taken.
- R9: In a read, a master NACK ends the transfer and SDA stays released. A master ACK makes the slave send the same register again.
- R10: When bit 7 of the last byte written to 22h is 1 (0 after reset), SCL or SDA held low with no change for more than TMO_CYC clocks returns the slave to idle. With the bit at 0, the transfer resumes after such a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | High pulls the data line low (open drain) |
| rf_addr | output | 8 | Register file address for either strobe |
| rf_rd | output | 1 | Read strobe, one cycle |
| rf_rdata | input | 8 | Read data, valid while rf_rd is high |
| rf_wr | output | 1 | Write strobe, one cycle |
| rf_wdata | output | 8 | Write data |
| alert_req | input | 1 | Alarm logic has an alert pending |
| alert_done | output | 1 | One-cycle pulse: alert response was read |

## Verification
A wrong frame state shows up within one byte, because the ACK lands in the wrong clock or a bit arrives shifted, and the master's sample of SDA in the ninth clock catches it. A pointer that is lost or changed by mistake only shows on a later read that sets no pointer. The checks therefore re-read with plain reads after every transaction that must leave the pointer alone. A wrong address fold shows up at the next read of the read address, and a stray write strobe shows up in the strobe count. A timeout that is wired the wrong way shows up in the ninth clock of the byte that was interrupted: the ACK is there when it should not be, or missing when it should be.

// File: rtl/smbslv_pkg.sv
`timescale 1ns/1ps
package smbslv_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_SKIP} sl_state_e;
    typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} rx_kind_e;

    typedef struct packed {
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic tmo;
    } bus_ev_t;

    localparam byte_t ID_CODE  = 8'h61;
    localparam byte_t REV_CODE = 8'h00;
    localparam byte_t TMO_REG  = 8'h22;
    localparam byte_t SPLIT_LO = 8'h09;
    localparam byte_t SPLIT_HI = 8'h0E;
    localparam byte_t SPLIT_D  = 8'h06;

    function automatic logic shared_reg(byte_t a);
        return (a >= 8'h11 && a <= 8'h14) || a == 8'h19 || (a >= 8'h20 && a <= 8'h22);
    endfunction

    function automatic logic ext_readable(byte_t a);
        return (a <= 8'h08) || a == 8'h10 || shared_reg(a);
    endfunction

    function automatic logic const_reg(byte_t a);
        return a == 8'hFE || a == 8'hFF;
    endfunction

    function automatic logic writable(byte_t a);
        return (a >= SPLIT_LO && a <= 8'h0F) || shared_reg(a);
    endfunction

    function automatic logic ptr_valid(byte_t a);
        return ext_readable(a) || writable(a) || const_reg(a);
    endfunction

    function automatic byte_t wr_target(byte_t a);
        return (a >= SPLIT_LO && a <= SPLIT_HI) ? a - SPLIT_D : a;
    endfunction

    function automatic byte_t const_val(byte_t a);
        return (a == 8'hFE) ? ID_CODE : ((a == 8'hFF) ? REV_CODE : '0);
    endfunction
endpackage

// File: rtl/smbslv_deglitch.sv
`timescale 1ns/1ps
module smbslv_deglitch #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync;
    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync <= 2'b11;
            dout <= 1'b1;
            run  <= '0;
        end else begin
            sync <= {sync[0], din};
            if (sync[1] == dout) begin
                run <= '0;
            end else if (run == CW'(FILT_LEN - 1)) begin
                dout <= sync[1];
                run  <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end
    end

    // R1: the filtered line only moves toward the synchronized value
    assert_filt_follow_R1: assert property (@(posedge clk) disable iff (rst)
        (dout != $past(dout)) |-> (dout == $past(sync[1])));
endmodule

// File: rtl/smbslv_busev.sv
`timescale 1ns/1ps
module smbslv_busev
    import smbslv_pkg::*;
#(
    parameter int TMO_CYC = 6000000
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    input  logic    tmo_en,
    output bus_ev_t ev
);
    localparam int TW = $clog2(TMO_CYC + 1);

    logic          scl_q, sda_q, tmo_q, chg, idle_hi;
    logic [TW-1:0] low_cnt;

    assign chg     = (scl != scl_q) || (sda != sda_q);
    assign idle_hi = scl && sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
            low_cnt <= '0;
            tmo_q   <= 1'b0;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
            tmo_q <= tmo_en && !idle_hi && !chg && (low_cnt == TW'(TMO_CYC - 1));
            if (!tmo_en || idle_hi || chg)
                low_cnt <= '0;
            else if (low_cnt != TW'(TMO_CYC))
                low_cnt <= low_cnt + 1'b1;
        end
    end

    always_comb begin
        ev.sda   = sda;
        ev.rise  = scl && !scl_q;
        ev.fall  = !scl && scl_q;
        ev.start = scl && scl_q && sda_q && !sda;
        ev.stop  = scl && scl_q && !sda_q && sda;
        ev.tmo   = tmo_q;
    end

    // R10: no timeout event unless the enable was set
    assert_tmo_gate_R10: assert property (@(posedge clk) disable iff (rst)
        tmo_q |-> $past(tmo_en));
endmodule

// File: rtl/smb_reg_slave.sv
`timescale 1ns/1ps
module smb_reg_slave
    import smbslv_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = 7'h4C,
    parameter logic [6:0] ARA_ADDR = 7'h0C,
    parameter int         FILT_LEN = 3,
    parameter int         TMO_CYC  = 6000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] rf_addr,
    output logic       rf_rd,
    input  logic [7:0] rf_rdata,
    output logic       rf_wr,
    output logic [7:0] rf_wdata,
    input  logic       alert_req,
    output logic       alert_done
);
    localparam logic [CNT_W-1:0] BITS     = CNT_W'(BYTE_W);
    localparam byte_t            ARA_RESP = {OWN_ADDR, 1'b1};
    localparam byte_t            ARA_BYTE = {ARA_ADDR, 1'b1};

    logic       scl_f, sda_f;
    bus_ev_t    ev;
    sl_state_e  st;
    rx_kind_e   kind, nkind;
    logic       to_tx, ara, mack_ok, oe, done, tmo_en;
    logic       rd_q, wr_q;
    logic [CNT_W-1:0] cnt;
    byte_t      sh, tx, ptr, addr_q, wdat_q;
    logic       quiet, byte_done, own_hit, ara_hit, rd_fetch, ara_load, store;

    smbslv_deglitch #(.FILT_LEN(FILT_LEN)) i_flt_scl (
        .clk(clk), .rst(rst), .din(scl_i), .dout(scl_f));
    smbslv_deglitch #(.FILT_LEN(FILT_LEN)) i_flt_sda (
        .clk(clk), .rst(rst), .din(sda_i), .dout(sda_f));
    smbslv_busev #(.TMO_CYC(TMO_CYC)) i_busev (
        .clk(clk), .rst(rst), .scl(scl_f), .sda(sda_f), .tmo_en(tmo_en), .ev(ev));

    assign quiet     = !ev.tmo && !ev.start && !ev.stop;
    assign byte_done = quiet && st == S_RX && ev.fall && cnt == BITS;
    assign own_hit   = sh[BYTE_W-1:1] == OWN_ADDR;
    assign ara_hit   = sh == ARA_BYTE && alert_req;
    assign ara_load  = byte_done && kind == K_ADDR && !own_hit && ara_hit;
    assign rd_fetch  = (byte_done && kind == K_ADDR && own_hit && sh[0])
                     || (quiet && st == S_MACK && ev.rise && !ev.sda && !ara);
    assign store     = byte_done && kind == K_DATA;

    // Control: frame state, ACK drive, pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE; kind <= K_ADDR; nkind <= K_ADDR;
            to_tx <= 1'b0; ara <= 1'b0; mack_ok <= 1'b0; oe <= 1'b0; done <= 1'b0;
            cnt <= '0; sh <= '0; ptr <= '0;
        end else begin
            done <= 1'b0;
            if (ev.tmo || ev.stop) begin
                st <= S_IDLE;
                oe <= 1'b0;
            end else if (ev.start) begin
                st <= S_RX; kind <= K_ADDR; cnt <= '0; oe <= 1'b0; ara <= 1'b0;
            end else begin
                unique case (st)
                    S_RX: begin
                        if (ev.rise) begin
                            sh  <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (byte_done) begin
                            unique case (kind)
                                K_ADDR: begin
                                    if (own_hit) begin
                                        st <= S_ACK; oe <= 1'b1; to_tx <= sh[0]; nkind <= K_PTR;
                                    end else if (ara_hit) begin
                                        st <= S_ACK; oe <= 1'b1; to_tx <= 1'b1; ara <= 1'b1;
                                    end else begin
                                        st <= S_SKIP;
                                    end
                                end
                                K_PTR: begin
                                    if (ptr_valid(sh)) begin
                                        st <= S_ACK; oe <= 1'b1; to_tx <= 1'b0;
                                        nkind <= K_DATA; ptr <= sh;
                                    end else begin
                                        st <= S_SKIP;
                                    end
                                end
                                default: begin
                                    st <= S_ACK; oe <= 1'b1; to_tx <= 1'b0; nkind <= K_DATA;
                                end
                            endcase
                        end
                    end
                    S_ACK: begin
                        if (ev.fall) begin
                            cnt <= '0;
                            if (to_tx) begin
                                st <= S_TX; oe <= ~tx[BYTE_W-1];
                            end else begin
                                st <= S_RX; kind <= nkind; oe <= 1'b0;
                            end
                        end
                    end
                    S_TX: begin
                        if (ev.rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (ev.fall) begin
                            if (cnt == BITS) begin
                                oe <= 1'b0; st <= S_MACK;
                            end else begin
                                oe <= ~tx[3'd7 - cnt[2:0]];
                            end
                        end
                    end
                    S_MACK: begin
                        if (ev.rise) begin
                            mack_ok <= ~ev.sda;
                            if (ara) done <= 1'b1;
                        end else if (ev.fall) begin
                            cnt <= '0;
                            if (mack_ok) begin
                                st <= S_TX; oe <= ~tx[BYTE_W-1];
                            end else begin
                                st <= S_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Datapath: register file strobes, transmit byte, timeout enable copy
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0; wr_q <= 1'b0; addr_q <= '0; wdat_q <= '0; tx <= '0; tmo_en <= 1'b0;
        end else begin
            rd_q <= 1'b0;
            wr_q <= 1'b0;
            if (rd_q) tx <= rf_rdata;
            if (ara_load) begin
                tx <= ARA_RESP;
            end else if (rd_fetch) begin
                if (ext_readable(ptr)) begin
                    rd_q   <= 1'b1;
                    addr_q <= ptr;
                end else begin
                    tx <= const_val(ptr);
                end
            end
            if (store) begin
                if (writable(ptr)) begin
                    wr_q   <= 1'b1;
                    addr_q <= wr_target(ptr);
                    wdat_q <= sh;
                end
                if (ptr == TMO_REG) tmo_en <= sh[BYTE_W-1];
            end
        end
    end

    assign sda_oe     = oe;
    assign rf_addr    = addr_q;
    assign rf_rd      = rd_q;
    assign rf_wr      = wr_q;
    assign rf_wdata   = wdat_q;
    assign alert_done = done;

    // R2: SDA released while idle or ignoring the bus
    assert_skip_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (st == S_SKIP || st == S_IDLE) |-> !sda_oe);
    // R7: write strobe lasts one cycle
    assert_wr_once_R7: assert property (@(posedge clk) disable iff (rst)
        rf_wr |=> !rf_wr);
    // R4: read and write strobes never overlap
    assert_rw_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(rf_wr && rf_rd));
    // R8: alert_done only in an alert response transfer
    assert_done_ara_R8: assert property (@(posedge clk) disable iff (rst)
        alert_done |-> ara);
    // R10: a timeout event leaves the slave idle
    assert_tmo_idle_R10: assert property (@(posedge clk) disable iff (rst)
        ev.tmo |=> (st == S_IDLE && !sda_oe));
    // R3: pointer stable while a byte is sent
    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (st == S_TX) |-> $stable(ptr));
endmodule

// File: tb/test_smb_reg_slave.sv
`timescale 1ns/1ps
module test_smb_reg_slave;
    localparam int H   = 20;
    localparam int TMO = 300;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_w;
    logic       sda_oe, rf_rd, rf_wr, alert_req, alert_done;
    logic [7:0] rf_addr, rf_rdata, rf_wdata;
    logic [7:0] mem [256];
    int         wr_cnt, done_cnt;
    int         n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    assign sda_w    = sda_m & ~sda_oe;
    assign rf_rdata = rf_rd ? mem[rf_addr] : 8'h00;

    smb_reg_slave #(.TMO_CYC(TMO)) i_smb_reg_slave (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_w), .sda_oe(sda_oe),
        .rf_addr(rf_addr), .rf_rd(rf_rd), .rf_rdata(rf_rdata), .rf_wr(rf_wr),
        .rf_wdata(rf_wdata), .alert_req(alert_req), .alert_done(alert_done));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
            wr_cnt   <= 0;
            done_cnt <= 0;
        end else begin
            if (rf_wr) begin
                mem[rf_addr] <= rf_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (alert_done) done_cnt <= done_cnt + 1;
        end
    end

    // {write pointer, write data, read pointer, expected read}
    localparam logic [31:0] VEC [10] = '{
        32'h09_3C_03_3C, 32'h0A_05_04_05, 32'h0B_55_05_55, 32'h0E_11_08_11,
        32'h19_70_19_70, 32'h22_03_22_03, 32'h03_EE_03_3C, 32'h13_42_FE_61,
        32'h14_09_FF_00, 32'h0F_5A_0F_00};

    task automatic chk(string rq, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0;
    endtask

    task automatic bus_rstart;
        tick(H/2); sda_m = 1'b1; tick(H/2);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop;
        tick(H/2); sda_m = 1'b0; tick(H/2);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_bit(logic b);
        tick(H/2); sda_m = b; tick(H/2);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0;
    endtask

    task automatic recv_bit(output logic b);
        tick(H/2); sda_m = 1'b1; tick(H/2);
        scl_m = 1'b1; tick(H/2);
        b = sda_w; tick(H/2);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = !b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(!mack);
    endtask

    task automatic write_reg(logic [7:0] p, logic [7:0] d, output logic ok);
        logic a0, a1, a2;
        bus_start;
        send_byte(8'h98, a0);
        send_byte(p, a1);
        send_byte(d, a2);
        bus_stop;
        ok = a0 && a1 && a2;
    endtask

    task automatic read_reg(logic [7:0] p, output logic [7:0] d);
        logic a;
        bus_start;
        send_byte(8'h98, a);
        send_byte(p, a);
        bus_rstart;
        send_byte(8'h99, a);
        recv_byte(d, 1'b0);
        bus_stop;
    endtask

    task automatic plain_read(output logic [7:0] d);
        logic a;
        bus_start;
        send_byte(8'h99, a);
        recv_byte(d, 1'b0);
        bus_stop;
    endtask

    task automatic held_addr(output logic ack);
        logic b;
        bus_start;
        for (int i = 7; i >= 4; i--) send_bit(8'h98 >> i);
        tick(TMO + 100);
        for (int i = 3; i >= 0; i--) send_bit(8'h98 >> i);
        recv_bit(b);
        ack = !b;
    endtask

    task automatic run_all;
        logic       ok, a, b;
        logic [7:0] d;
        int         w0, d0;

        // Reset state
        chk("R1 reset sda_oe", sda_oe, 0);
        chk("R1 reset rf_wr", rf_wr, 0);
        chk("R8 reset alert_done", alert_done, 0);

        // Table: write, then read back through pointer set and repeated start
        for (int v = 0; v < 10; v++) begin
            write_reg(VEC[v][31:24], VEC[v][23:16], ok);
            chk("R1 R3 write acks", ok, 1);
            read_reg(VEC[v][15:8], d);
            chk("R4 R5 R7 table readback", d, VEC[v][7:0]);
        end

        // R3: pointer persists into a read with no pointer set
        read_reg(8'h05, d);
        plain_read(d);
        chk("R3 plain read keeps pointer", d, 8'h55);

        // R2: foreign address ignored
        w0 = wr_cnt;
        bus_start;
        send_byte(8'h9A, a);
        chk("R2 foreign address no ack", a, 0);
        send_byte(8'h19, a);
        chk("R2 later byte no ack", a, 0);
        bus_stop;
        chk("R2 no write strobe", wr_cnt, w0);

        // R6: unimplemented pointer
        read_reg(8'h19, d);
        bus_start;
        send_byte(8'h98, a);
        send_byte(8'h30, a);
        chk("R6 bad pointer nack", a, 0);
        send_byte(8'h77, a);
        bus_stop;
        chk("R6 no write strobe", wr_cnt, w0);
        plain_read(d);
        chk("R6 pointer unchanged", d, 8'h70);

        // R9: master ACK repeats, master NACK releases
        bus_start;
        send_byte(8'h99, a);
        recv_byte(d, 1'b1);
        chk("R9 first byte", d, 8'h70);
        recv_byte(d, 1'b0);
        chk("R9 repeat after master ack", d, 8'h70);
        recv_bit(b);
        chk("R9 released after nack", b, 1);
        bus_stop;

        // R8: alert response
        alert_req = 1'b0;
        bus_start;
        send_byte(8'h19, a);
        chk("R8 no ack without alert", a, 0);
        bus_stop;
        alert_req = 1'b1;
        d0 = done_cnt;
        bus_start;
        send_byte(8'h19, a);
        chk("R8 ack with alert", a, 1);
        recv_byte(d, 1'b0);
        chk("R8 response byte", d, 8'h99);
        bus_stop;
        chk("R8 alert_done pulse", done_cnt, d0 + 1);
        alert_req = 1'b0;

        // R10: hold SCL low in an address byte, timeout off then on
        held_addr(a);
        chk("R10 disabled keeps transfer", a, 1);
        bus_stop;
        write_reg(8'h22, 8'h83, ok);
        held_addr(a);
        chk("R10 enabled drops transfer", a, 0);
        bus_stop;
        read_reg(8'h05, d);
        chk("R10 recovers after timeout", d, 8'h55);
    endtask

    initial begin
        alert_req = 1'b0;
        tick(5);
        rst = 1'b0;
        tick(5);
        fork
            run_all;
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: run did not finish");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule